// File: doc/BRIEF.md
# SDI Receive Timing Flag Extractor

This block sits after word alignment in a serial digital video receiver. It watches a stream of 10-bit words, one word for each clock on which the word-valid strobe is high. It spots timing reference sequences: three preamble words (all ones, then two all-zero words) followed by a status word. From the status word it produces line-level timing flags. These are a one-cycle marker for each sequence, a horizontal blanking level, a vertical blanking level and a field indicator.

The block also counts lines between frame boundaries. It raises a lock indication once several consecutive frames have the same structure. All outputs are registered. A sequence is recognised when its status word is accepted, so the flags describe the input stream delayed by three accepted words. Relative to that delayed view, the marker lands on the first preamble word.

Top module: `sdi_timing_extract`

## Requirements
- R1: `trs_mark` is high for exactly one cycle, in the cycle after an accepted word that directly follows three accepted words 3FF, 000, 000 (oldest first). The accepted word that completes the sequence is the status word. In the input stream delayed by three accepted words, this is the cycle that holds the 3FF word.
- R2: In the status word, bit 8 carries the field bit F, bit 7 carries the vertical blanking bit V, and bit 6 carries H. H=1 marks an end-of-active-video sequence (EAV) and H=0 marks a start-of-active-video sequence (SAV).
- R3: `hsync` goes high together with the marker of an EAV and goes low together with the marker of an SAV. It does not change at any other time.
- R4: `vsync` takes the V bit of each EAV in the marker cycle. It keeps its value across SAVs and across ordinary words.
- R5: `field` takes the F bit of each EAV in the marker cycle. It therefore stays 0 for progressive video, where F is always 0.
- R6: Words presented while `word_vld` is low are ignored. They neither start nor break a preamble, even when their value is 3FF or 000, and they never cause a marker.
- R7: A frame boundary is an EAV whose (F,V) is (0,1) when the previous EAV's (F,V) differed. Before the first EAV after reset, the previous (F,V) is taken as (0,0). A frame's total line count is its number of EAVs, including the boundary EAV. Its active line count is its number of EAVs with V=0.
- R8: The first boundary after reset only starts counting. `locked` rises at the boundary that ends the third consecutive frame with equal total and active line counts.
- R9: A boundary that ends a frame whose total or active count differs from the previous frame clears `locked` in that marker cycle. The match count then restarts with that frame as the first.
- R10: While `rst` is high and in the first cycle after it, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| word_vld | input | 1 | High when `word_in` carries a stream word |
| word_in | input | 10 | Received, aligned video word |
| trs_mark | output | 1 | One-cycle pulse per timing reference sequence |
| hsync | output | 1 | Horizontal blanking level |
| vsync | output | 1 | Vertical blanking level |
| field | output | 1 | Current field: 0 first, 1 second |
| locked | output | 1 | Frame structure repeated for enough frames |

## Verification
The hardest case to reach is the loss and regain of lock. The right flip must come at one specific boundary and depend only on the previous frame's counts. The stimulus therefore builds whole frames from line tasks and runs the following sequence: several identical progressive frames, then a frame one line longer, then a frame with the same total but a different active count, then interlaced frames whose field change triggers the boundary rule. Invalid cycles carrying 3FF and 000 are woven into the stream, including inside preambles. This shows that gaps neither create nor break a sequence.

// File: rtl/sdi_tfx_pkg.sv
package sdi_tfx_pkg;

  typedef struct packed {
    logic fld;
    logic vblk;
    logic hbit;
  } xyz_t;

endpackage

// File: rtl/sdi_trs_detect.sv
module sdi_trs_detect
  import sdi_tfx_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word_in,
  output logic              hit,
  output xyz_t              xyz
);

  localparam int HIST_N = 3;

  logic [HIST_N-1:0][WORD_W-1:0] hist;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist[0] <= '0;
    end else if (word_vld) begin
      hist[0] <= word_in;
    end
  end

  for (genvar gi = 1; gi < HIST_N; gi++) begin : g_hist
    always_ff @(posedge clk) begin
      if (rst) begin
        hist[gi] <= '0;
      end else if (word_vld) begin
        hist[gi] <= hist[gi-1];
      end
    end
  end

  assign hit = word_vld && (hist[2] == '1) && (hist[1] == '0) && (hist[0] == '0);

  assign xyz.fld  = word_in[WORD_W-2];
  assign xyz.vblk = word_in[WORD_W-3];
  assign xyz.hbit = word_in[WORD_W-4];

  // R6: idle words leave the preamble history untouched
  a_r6_hist_hold: assert property (@(posedge clk) disable iff (rst)
    !word_vld |=> $stable(hist));

endmodule

// File: rtl/sdi_timing_flags.sv
module sdi_timing_flags
  import sdi_tfx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  xyz_t xyz,
  output logic trs_mark,
  output logic hsync,
  output logic vsync,
  output logic field
);

  always_ff @(posedge clk) begin
    if (rst) begin
      trs_mark <= 1'b0;
      hsync    <= 1'b0;
      vsync    <= 1'b0;
      field    <= 1'b0;
    end else begin
      trs_mark <= hit;
      if (hit) begin
        hsync <= xyz.hbit;
        if (xyz.hbit) begin
          vsync <= xyz.vblk;
          field <= xyz.fld;
        end
      end
    end
  end

  // R1: marker never lasts two cycles
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
    trs_mark |=> !trs_mark);

  // R3: hsync edges only with a marker
  a_r3_hs_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync) |-> trs_mark);
  a_r3_hs_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(hsync) |-> trs_mark);

  // R4, R5: vertical and field levels only move on a marker
  a_r4_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !trs_mark |-> ($stable(vsync) && $stable(field)));

endmodule

// File: rtl/sdi_frame_lock.sv
module sdi_frame_lock
  import sdi_tfx_pkg::*;
#(
  parameter int LINE_W      = 12,
  parameter int LOCK_FRAMES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  xyz_t xyz,
  output logic locked
);

  localparam int MW = $clog2(LOCK_FRAMES + 1);
  localparam logic [MW-1:0] LOCK_M = MW'(LOCK_FRAMES);

  logic              prev_f, prev_v;
  logic              started, have_ref;
  logic [LINE_W-1:0] line_cnt, act_cnt, ref_lines, ref_act;
  logic [MW-1:0]     match_cnt, match_inc;
  logic              eav, boundary, same_cnt;

  assign eav       = hit && xyz.hbit;
  assign boundary  = eav && !xyz.fld && xyz.vblk && !(!prev_f && prev_v);
  assign same_cnt  = (line_cnt == ref_lines) && (act_cnt == ref_act);
  assign match_inc = (match_cnt == LOCK_M) ? match_cnt : match_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_f    <= 1'b0;
      prev_v    <= 1'b0;
      started   <= 1'b0;
      have_ref  <= 1'b0;
      line_cnt  <= '0;
      act_cnt   <= '0;
      ref_lines <= '0;
      ref_act   <= '0;
      match_cnt <= '0;
      locked    <= 1'b0;
    end else if (eav) begin
      prev_f <= xyz.fld;
      prev_v <= xyz.vblk;
      if (boundary) begin
        line_cnt <= LINE_W'(1);
        act_cnt  <= '0;
        if (!started) begin
          started <= 1'b1;
        end else if (!have_ref || !same_cnt) begin
          have_ref  <= 1'b1;
          ref_lines <= line_cnt;
          ref_act   <= act_cnt;
          match_cnt <= MW'(1);
          locked    <= (LOCK_FRAMES <= 1);
        end else begin
          match_cnt <= match_inc;
          locked    <= (match_inc == LOCK_M);
        end
      end else begin
        line_cnt <= line_cnt + 1'b1;
        act_cnt  <= act_cnt + LINE_W'(!xyz.vblk);
      end
    end
  end

  // R8: lock only appears at a frame boundary
  a_r8_rise_at_boundary: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(boundary));

  // R9: lock only drops at a frame boundary
  a_r9_fall_at_boundary: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> $past(boundary));

endmodule

// File: rtl/sdi_timing_extract.sv
module sdi_timing_extract
  import sdi_tfx_pkg::*;
#(
  parameter int WORD_W      = 10,
  parameter int LINE_W      = 12,
  parameter int LOCK_FRAMES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word_in,
  output logic              trs_mark,
  output logic              hsync,
  output logic              vsync,
  output logic              field,
  output logic              locked
);

  logic hit;
  xyz_t xyz;

  sdi_trs_detect #(.WORD_W(WORD_W)) u_detect (
    .clk(clk), .rst(rst), .word_vld(word_vld), .word_in(word_in),
    .hit(hit), .xyz(xyz)
  );

  sdi_timing_flags u_flags (
    .clk(clk), .rst(rst), .hit(hit), .xyz(xyz),
    .trs_mark(trs_mark), .hsync(hsync), .vsync(vsync), .field(field)
  );

  sdi_frame_lock #(.LINE_W(LINE_W), .LOCK_FRAMES(LOCK_FRAMES)) u_lock (
    .clk(clk), .rst(rst), .hit(hit), .xyz(xyz), .locked(locked)
  );

  // R6: an idle cycle can never produce a marker
  a_r6_idle_no_mark: assert property (@(posedge clk) disable iff (rst)
    !$past(word_vld) |-> !trs_mark);

  // R8, R9: lock changes coincide with an EAV marker
  a_r8_lock_with_mark: assert property (@(posedge clk) disable iff (rst)
    !$stable(locked) |-> (trs_mark && hsync));

endmodule

// File: tb/sdi_timing_extract_tb_top.sv
module sdi_timing_extract_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       word_vld = 1'b0;
  logic [9:0] word_in = '0;
  logic       trs_mark, hsync, vsync, field, locked;

  always #4 clk = ~clk;

  sdi_timing_extract dut_i (
    .clk(clk), .rst(rst), .word_vld(word_vld), .word_in(word_in),
    .trs_mark(trs_mark), .hsync(hsync), .vsync(vsync), .field(field),
    .locked(locked)
  );

  int checks = 0;
  int errors = 0;
  int gaps_on = 0;
  int gap_ctr = 0;
  int dat_ctr = 0;

  // behavioural reference
  int h0, h1, h2;
  bit e_trs, e_hs, e_vs, e_fd, e_lk;
  int pf, pv, started, have, lc, ac, rl, ra, m;

  always @(posedge clk) begin
    if (rst) begin
      h0 = 0; h1 = 0; h2 = 0;
      e_trs = 0; e_hs = 0; e_vs = 0; e_fd = 0; e_lk = 0;
      pf = 0; pv = 0; started = 0; have = 0; lc = 0; ac = 0; rl = 0; ra = 0; m = 0;
    end else begin
      e_trs = 0;
      if (word_vld) begin
        if (h2 == 10'h3FF && h1 == 0 && h0 == 0) begin
          int f, v;
          f = word_in[8]; v = word_in[7];
          e_trs = 1;
          if (word_in[6]) begin
            e_hs = 1; e_vs = v[0]; e_fd = f[0];
            if (f == 0 && v == 1 && !(pf == 0 && pv == 1)) begin
              if (!started) started = 1;
              else if (!have || lc != rl || ac != ra) begin
                have = 1; rl = lc; ra = ac; m = 1; e_lk = 0;
              end else begin
                m = m + 1; e_lk = (m >= 3);
              end
              lc = 1; ac = 0;
            end else begin
              lc = lc + 1; ac = ac + (v == 0 ? 1 : 0);
            end
            pf = f; pv = v;
          end else begin
            e_hs = 0;
          end
        end
        h2 = h1; h1 = h0; h0 = word_in;
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1 trs_mark", trs_mark, e_trs);
    chk("R3 hsync", hsync, e_hs);
    chk("R4 vsync", vsync, e_vs);
    chk("R5 field", field, e_fd);
    chk("R8 locked", locked, e_lk);
  endtask

  task automatic put(input logic v, input logic [9:0] w);
    @(negedge clk);
    compare_all();
    word_vld = v;
    word_in  = w;
  endtask

  task automatic send(input logic [9:0] w);
    if (gaps_on != 0) begin
      gap_ctr++;
      if (gap_ctr % 3 == 0) put(1'b0, (gap_ctr % 2 == 0) ? 10'h3FF : 10'h000);
    end
    put(1'b1, w);
  endtask

  function automatic logic [9:0] xyz_word(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
  endfunction

  task automatic send_trs(input logic f, input logic v, input logic h);
    send(10'h3FF); send(10'h000); send(10'h000); send(xyz_word(f, v, h));
  endtask

  task automatic send_line(input logic f, input logic v);
    send_trs(f, v, 1'b1);
    for (int i = 0; i < 3; i++) begin dat_ctr++; send(10'h200 + 10'(dat_ctr % 64)); end
    send_trs(f, v, 1'b0);
    for (int i = 0; i < 4; i++) begin dat_ctr++; send(10'h100 + 10'(dat_ctr % 64)); end
  endtask

  task automatic send_prog(input int total, input int vb);
    for (int l = 0; l < total; l++) send_line(1'b0, l < vb);
  endtask

  task automatic send_intl(input int vb, input int act);
    for (int l = 0; l < vb; l++)  send_line(1'b0, 1'b1);
    for (int l = 0; l < act; l++) send_line(1'b0, 1'b0);
    for (int l = 0; l < vb; l++)  send_line(1'b1, 1'b1);
    for (int l = 0; l < act; l++) send_line(1'b1, 1'b0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin : main
    // R10: reset state
    repeat (3) begin
      @(negedge clk);
      chk("R10 trs_mark", trs_mark, 1'b0); chk("R10 hsync", hsync, 1'b0);
      chk("R10 vsync", vsync, 1'b0); chk("R10 field", field, 1'b0);
      chk("R10 locked", locked, 1'b0);
    end
    rst = 1'b0;
    @(negedge clk);
    chk("R10 after release", trs_mark | hsync | vsync | field | locked, 1'b0);

    // R8: identical progressive frames reach lock
    repeat (5) send_prog(10, 3);
    send_line(1'b0, 1'b1);
    put(1'b0, 10'h0);
    chk("R8 locked after repeats", locked, 1'b1);
    chk("R4 vsync in blanking line", vsync, 1'b1);

    // R9: longer frame drops lock
    send_prog(10, 3);
    send_prog(11, 3);
    send_line(1'b0, 1'b1);
    put(1'b0, 10'h0);
    chk("R9 lock dropped on total change", locked, 1'b0);
    repeat (4) send_prog(10, 3);
    send_line(1'b0, 1'b1);
    put(1'b0, 10'h0);
    chk("R8 relocked", locked, 1'b1);

    // R9: same total, different active count
    send_prog(10, 3);
    send_prog(10, 4);
    send_line(1'b0, 1'b1);
    put(1'b0, 10'h0);
    chk("R9 lock dropped on active change", locked, 1'b0);

    // R5, R7: interlaced frames with idle gaps
    gaps_on = 1;
    repeat (5) send_intl(2, 4);
    send_line(1'b1, 1'b0);
    put(1'b0, 10'h0);
    chk("R5 field in second field", field, 1'b1);
    chk("R7 interlaced lock", locked, 1'b1);
    gaps_on = 0;

    // R6: idle 3FF/000 inside a preamble does not break it
    put(1'b1, 10'h3FF); put(1'b0, 10'h3FF); put(1'b1, 10'h000);
    put(1'b0, 10'h3FF); put(1'b1, 10'h000); put(1'b1, xyz_word(1'b0, 1'b0, 1'b0));
    put(1'b0, 10'h000);
    chk("R6 preamble across idle", trs_mark, 1'b1);
    chk("R2 SAV clears hsync", hsync, 1'b0);

    // R6: idle zero does not complete a preamble
    put(1'b1, 10'h3FF); put(1'b1, 10'h000); put(1'b0, 10'h000);
    put(1'b1, xyz_word(1'b0, 1'b1, 1'b1));
    put(1'b0, 10'h000);
    chk("R6 idle word ignored", trs_mark, 1'b0);
    chk("R6 hsync untouched", hsync, 1'b0);

    // R2: EAV bit decode
    put(1'b1, 10'h3FF); put(1'b1, 10'h000); put(1'b1, 10'h000);
    put(1'b1, xyz_word(1'b1, 1'b1, 1'b1));
    put(1'b0, 10'h000);
    chk("R2 EAV sets hsync", hsync, 1'b1);
    chk("R2 F decoded", field, 1'b1);
    chk("R2 V decoded", vsync, 1'b1);
    put(1'b0, 10'h000);
    chk("R1 pulse ends", trs_mark, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule